// File: doc/BRIEF.md
# Mode-Dependent Address Mapper

This block sits between a small CPU with a 16-bit address bus and a 512 KB RAM. It widens each CPU address to a 19-bit physical address and raises either a RAM select or an I/O select. The mode input chooses one of two maps. In user mode the 64 KB space is split into three regions, 16 KB, 16 KB and 32 KB, and each region is relocated by its own page register. This gives every process a private space. No I/O is visible to a process, and it cannot see memory that its page registers do not point at.

In supervisor mode the map is mostly fixed. The lowest 16 KB and the top 16 KB map to the matching physical addresses. The range from 0x8000 to 0xBFFF is I/O. The 16 KB at 0x4000 is a movable window, placed by a window register, so the kernel can reach any 16 KB block, including user memory. The four mapping registers are written by ordinary CPU stores into four fixed addresses of the I/O range, and only in supervisor mode. The operating system reprograms the user pages before each return to a process.

Top module: `mode_addr_mapper`

## Requirements
- R1: In user mode, a CPU address in 0x0000–0x3FFF maps to {page0[4:0], addr[13:0]}, and an address in 0x4000–0x7FFF maps to {page1[4:0], addr[13:0]}.
- R2: In user mode, a CPU address in 0x8000–0xFFFF maps to {page2[3:0], addr[14:0]}. Page2 holds only 4 bits, so a written value keeps only its low 4 data bits.
- R3: In supervisor mode, a CPU address in 0x0000–0x3FFF maps to the same physical address (0x00000–0x03FFF).
- R4: In supervisor mode, a CPU address in 0x4000–0x7FFF maps to {window[4:0], addr[13:0]}.
- R5: In supervisor mode, a CPU address in 0x8000–0xBFFF gives io_cs_o=1 and ram_cs_o=0. phys_addr_o then carries the zero-extended CPU address.
- R6: In supervisor mode, a CPU address in 0xC000–0xFFFF maps to physical 0x0C000–0x0FFFF, which is the zero-extended CPU address.
- R7: In user mode, ram_cs_o=1 and io_cs_o=0 for every address.
- R8: ram_cs_o and io_cs_o are never both 1. Both outputs, and phys_addr_o, follow the address and mode inputs in the same cycle, with no clock edge between them.
- R9: A store with supervisor_i=1 and cpu_wr_i=1 to address REG_BASE+k (default 0xBF00+k) loads the low data bits into a register at the next rising clock edge. The register is chosen by k: 0 is page0, 1 is page1, 2 is page2 and 3 is the window. Stores to any other address change no register.
- R10: A store with supervisor_i=0 changes no mapping register, even at a register address.
- R11: After an asynchronous reset, all four registers are zero. User pages then point at physical block 0, and the window points at block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for register writes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supervisor_i | input | 1 | 1 = supervisor map, 0 = user map |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| phys_addr_o | output | 19 | Physical RAM address |
| ram_cs_o | output | 1 | RAM select |
| io_cs_o | output | 1 | I/O range select |

## Verification
Some properties are checked on every cycle:
- The two selects never assert together.
- User mode never reaches I/O.
- The identity regions of the supervisor map hold.
- The page offset passes through in user mode.
- An accepted store lands in its register one edge later.
- A user-mode store leaves all registers unchanged.

Only the bench scenarios can show three further behaviours: that each relocated region uses the right register and the right split between block number and offset, that page2 drops its fifth bit, and that stores to neighbouring addresses or after reset leave the map as a reference model predicts.

// File: rtl/amap_pkg.sv
package amap_pkg;
  localparam int CPU_AW    = 16;
  localparam int PHYS_AW   = 19;
  localparam int SMALL_OFF = 14;                   // 16 KB page offset bits
  localparam int LARGE_OFF = 15;                   // 32 KB page offset bits
  localparam int SMALL_BW  = PHYS_AW - SMALL_OFF;  // 5-bit block number
  localparam int LARGE_BW  = PHYS_AW - LARGE_OFF;  // 4-bit block number
  localparam int NUM_REGS  = 4;
  localparam int IDX_W     = $clog2(NUM_REGS);

  typedef enum logic [IDX_W-1:0] {
    IDX_PAGE0  = 2'd0,
    IDX_PAGE1  = 2'd1,
    IDX_PAGE2  = 2'd2,
    IDX_WINDOW = 2'd3
  } map_idx_e;

  typedef logic [NUM_REGS-1:0][SMALL_BW-1:0] map_regs_t;
endpackage

// File: rtl/amap_wr_decode.sv
module amap_wr_decode
  import amap_pkg::*;
#(
  parameter logic [CPU_AW-1:0] REG_BASE = 16'hBF00
) (
  input  logic              supervisor_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic              cpu_wr_i,
  output logic              we_o,
  output map_idx_e          idx_o
);
  logic hit;

  assign hit   = (cpu_addr_i[CPU_AW-1:IDX_W] == REG_BASE[CPU_AW-1:IDX_W]);
  assign we_o  = cpu_wr_i & supervisor_i & hit;
  assign idx_o = map_idx_e'(cpu_addr_i[IDX_W-1:0]);
endmodule

// File: rtl/amap_regs.sv
module amap_regs
  import amap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  map_idx_e          idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output map_regs_t         regs_o
);
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:SMALL_BW];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam int KEEP_W = (k == int'(IDX_PAGE2)) ? LARGE_BW : SMALL_BW;
    localparam logic [SMALL_BW-1:0] KEEP_MASK = SMALL_BW'((1 << KEEP_W) - 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[k] <= '0;
      end else if (we_i && (int'(idx_i) == k)) begin
        regs_o[k] <= wdata_i[SMALL_BW-1:0] & KEEP_MASK;
      end
    end
  end
endmodule

// File: rtl/amap_xlate.sv
module amap_xlate
  import amap_pkg::*;
(
  input  logic               supervisor_i,
  input  logic [CPU_AW-1:0]  cpu_addr_i,
  input  map_regs_t          regs_i,
  output logic [PHYS_AW-1:0] phys_addr_o,
  output logic               ram_cs_o,
  output logic               io_cs_o
);
  localparam int ZX_W = PHYS_AW - CPU_AW;

  logic [1:0] quad;
  logic       unused_pg2_hi;

  assign quad          = cpu_addr_i[CPU_AW-1 -: 2];
  assign unused_pg2_hi = regs_i[IDX_PAGE2][SMALL_BW-1];

  always_comb begin
    phys_addr_o = {{ZX_W{1'b0}}, cpu_addr_i};
    ram_cs_o    = 1'b1;
    io_cs_o     = 1'b0;
    if (!supervisor_i) begin
      unique case (quad)
        2'b00:   phys_addr_o = {regs_i[IDX_PAGE0], cpu_addr_i[SMALL_OFF-1:0]};
        2'b01:   phys_addr_o = {regs_i[IDX_PAGE1], cpu_addr_i[SMALL_OFF-1:0]};
        default: phys_addr_o = {regs_i[IDX_PAGE2][LARGE_BW-1:0],
                                cpu_addr_i[LARGE_OFF-1:0]};
      endcase
    end else begin
      unique case (quad)
        2'b01:   phys_addr_o = {regs_i[IDX_WINDOW], cpu_addr_i[SMALL_OFF-1:0]};
        2'b10: begin
          ram_cs_o = 1'b0;
          io_cs_o  = 1'b1;
        end
        default: ;  // identity regions
      endcase
    end
  end
endmodule

// File: rtl/mode_addr_mapper.sv
module mode_addr_mapper
  import amap_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [CPU_AW-1:0] REG_BASE = 16'hBF00
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               supervisor_i,
  input  logic [CPU_AW-1:0]  cpu_addr_i,
  input  logic               cpu_wr_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  output logic [PHYS_AW-1:0] phys_addr_o,
  output logic               ram_cs_o,
  output logic               io_cs_o
);
  logic      map_we;
  map_idx_e  map_idx;
  map_regs_t map_q;

  amap_wr_decode #(.REG_BASE(REG_BASE)) u_dec (
    .supervisor_i (supervisor_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wr_i     (cpu_wr_i),
    .we_o         (map_we),
    .idx_o        (map_idx)
  );

  amap_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (map_we),
    .idx_i   (map_idx),
    .wdata_i (cpu_wdata_i),
    .regs_o  (map_q)
  );

  amap_xlate u_xlate (
    .supervisor_i (supervisor_i),
    .cpu_addr_i   (cpu_addr_i),
    .regs_i       (map_q),
    .phys_addr_o  (phys_addr_o),
    .ram_cs_o     (ram_cs_o),
    .io_cs_o      (io_cs_o)
  );
endmodule

// File: rtl/mode_addr_mapper_chk.sv
module mode_addr_mapper_chk
  import amap_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [CPU_AW-1:0] REG_BASE = 16'hBF00
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               supervisor_i,
  input logic [CPU_AW-1:0]  cpu_addr_i,
  input logic               cpu_wr_i,
  input logic [DATA_W-1:0]  cpu_wdata_i,
  input logic [PHYS_AW-1:0] phys_addr_o,
  input logic               ram_cs_o,
  input logic               io_cs_o,
  input map_regs_t          map_q
);
  logic reg_hit;
  assign reg_hit = cpu_addr_i[CPU_AW-1:IDX_W] == REG_BASE[CPU_AW-1:IDX_W];

  assert_cs_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_cs_o && io_cs_o));

  assert_user_no_io_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supervisor_i |-> (ram_cs_o && !io_cs_o));

  assert_user_offset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supervisor_i |-> phys_addr_o[SMALL_OFF-1:0] == cpu_addr_i[SMALL_OFF-1:0]);

  assert_kern_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supervisor_i && cpu_addr_i[15:14] == 2'b00) |->
      (ram_cs_o && phys_addr_o == PHYS_AW'(cpu_addr_i)));

  assert_kern_io_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supervisor_i && cpu_addr_i[15:14] == 2'b10) |-> (io_cs_o && !ram_cs_o));

  assert_kern_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supervisor_i && cpu_addr_i[15:14] == 2'b11) |->
      (ram_cs_o && phys_addr_o == PHYS_AW'(cpu_addr_i)));

  assert_wr_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supervisor_i && cpu_wr_i && reg_hit && cpu_addr_i[1:0] == 2'd0) |=>
      map_q[0] == $past(cpu_wdata_i[SMALL_BW-1:0]));

  assert_user_wr_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supervisor_i && cpu_wr_i) |=> $stable(map_q));
endmodule

bind mode_addr_mapper mode_addr_mapper_chk #(.DATA_W(DATA_W), .REG_BASE(REG_BASE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .supervisor_i (supervisor_i),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_wr_i     (cpu_wr_i),
  .cpu_wdata_i  (cpu_wdata_i),
  .phys_addr_o  (phys_addr_o),
  .ram_cs_o     (ram_cs_o),
  .io_cs_o      (io_cs_o),
  .map_q        (map_q)
);

// File: tb/tb_mode_addr_mapper.sv
module tb_mode_addr_mapper;
  localparam logic [15:0] BASE = 16'hBF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sup = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [18:0] phys;
  logic        ram_cs, io_cs;

  int n_tests = 0;
  int n_fail  = 0;
  logic [4:0] m [4];

  always #10 clk = ~clk;  // 50 MHz

  mode_addr_mapper dut (
    .clk_i(clk), .rst_ni(rst_n), .supervisor_i(sup), .cpu_addr_i(addr),
    .cpu_wr_i(wr), .cpu_wdata_i(wdata), .phys_addr_o(phys),
    .ram_cs_o(ram_cs), .io_cs_o(io_cs)
  );

  function automatic logic [18:0] exp_phys(logic [15:0] a, logic s);
    if (!s) begin
      case (a[15:14])
        2'b00:   return {m[0], a[13:0]};
        2'b01:   return {m[1], a[13:0]};
        default: return {m[2][3:0], a[14:0]};
      endcase
    end
    if (a[15:14] == 2'b01) return {m[3], a[13:0]};
    return {3'b000, a};
  endfunction

  function automatic string req_of(logic [15:0] a, logic s);
    if (!s) return (a[15]) ? "R2" : "R1";
    case (a[15:14])
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic probe(input logic [15:0] a, input logic s, input string tag);
    logic [18:0] ep;
    logic er, ei;
    @(negedge clk);
    addr = a; sup = s; wr = 1'b0;
    #5;
    ep = exp_phys(a, s);
    er = !(s && a[15:14] == 2'b10);
    ei = !er;
    n_tests++;
    if (phys !== ep || ram_cs !== er || io_cs !== ei) begin
      n_fail++;
      $display("FAIL %s %s addr=%h sup=%0b: phys=%h ram=%0b io=%0b expected phys=%h ram=%0b io=%0b",
               tag, req_of(a, s), a, s, phys, ram_cs, io_cs, ep, er, ei);
    end
  endtask

  task automatic store(input logic [15:0] a, input logic [7:0] d, input logic s);
    @(negedge clk);
    addr = a; sup = s; wr = 1'b1; wdata = d;
    @(posedge clk);
    if (s && a[15:2] == BASE[15:2]) begin
      if (a[1:0] == 2'd2) m[2] = {1'b0, d[3:0]};
      else                m[a[1:0]] = d[4:0];
    end
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R11: reset leaves every register at zero
    probe(16'h1234, 1'b0, "R11");
    probe(16'h5678, 1'b0, "R11");
    probe(16'hFEDC, 1'b0, "R11");
    probe(16'h6ABC, 1'b1, "R11");

    // R9: program each register
    store(BASE + 16'd0, 8'h13, 1'b1);
    store(BASE + 16'd1, 8'h1E, 1'b1);
    store(BASE + 16'd2, 8'hFF, 1'b1);  // R2: fifth bit dropped
    store(BASE + 16'd3, 8'h0A, 1'b1);
    probe(16'h0000, 1'b0, "R9");
    probe(16'h7FFF, 1'b0, "R9");
    probe(16'h8000, 1'b0, "R2");
    probe(16'hFFFF, 1'b0, "R2");
    probe(16'h4001, 1'b1, "R4");
    probe(16'h3FFF, 1'b1, "R3");
    probe(16'hBFFF, 1'b1, "R5");
    probe(16'hC000, 1'b1, "R6");
    probe(16'hBF00, 1'b0, "R7");

    // R10: user-mode stores change nothing
    store(BASE + 16'd0, 8'h05, 1'b0);
    store(BASE + 16'd3, 8'h1F, 1'b0);
    probe(16'h2222, 1'b0, "R10");
    probe(16'h4444, 1'b1, "R10");

    // R9: neighbouring addresses decode nothing
    store(BASE + 16'd4, 8'h1F, 1'b1);
    store(BASE - 16'd1, 8'h1F, 1'b1);
    probe(16'h0100, 1'b0, "R9");
    probe(16'h4100, 1'b1, "R9");

    // R8 and regional mapping under random traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic s;
      a = 16'($urandom);
      s = 1'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        a = BASE + 16'($urandom_range(0, 5)) - 16'd1;
        store(a, 8'($urandom), s);
      end else begin
        probe(a, s, "R8");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule